// File: doc/BRIEF.md
# I/O Port Configuration Address Router

This block sits beside a processor's I/O-space access path and decides where each port access lands. It keeps one 32-bit configuration-address register. Software loads that register with a full-width access to the address port 0xCF8. It then reaches configuration space through a four-byte data window at ports 0xCFC to 0xCFF.

The router looks at each access (16-bit port number, size in bytes, direction, write data) and returns two things in the same cycle. The first is a target class: the address register, configuration space, plain I/O space, or none. The second is the physical address that the downstream fabric should use. The register's top bit enables the window. The byte lane within the selected configuration dword comes from the two low port bits. Every port outside the address register and the window goes to I/O space. Issuing the downstream transaction is left to the fabric.

Top module: `cfgr_top`

## Requirements
- R1: After reset the configuration-address register reads as zero, so the data window starts out disabled.
- R2: A valid access to port 0xCF8 with size exactly 4 returns target class 1 (address register) and physical address REG_PA (default 0). A write loads accWdata into the register at the clock edge. A read returns the register value on rdData.
- R3: An access to port 0xCF8 with size other than 4 returns target class 3 (I/O space) with address IO_PREFIX | port, and leaves the register unchanged.
- R4: With register bit 31 set, a valid access to ports 0xCFC to 0xCFF returns target class 2 (configuration space) with address CFG_PREFIX | {register bits 30..2, port bits 1..0}.
- R5: With register bit 31 clear, a data-window access returns target class 0 (none) and physical address 0. A read of the window returns all ones on rdData.
- R6: Any valid access to another port (for example 0xCF9, 0xCFB, 0xD00, 0x0080) returns target class 3 with address IO_PREFIX | port.
- R7: A register write takes effect at its clock edge, and a window access in the very next cycle already uses the new value.
- R8: When accValid is low the target class is 0, the address is 0, and the register keeps its value whatever the other inputs are.
- R9: Register bits 1..0 never reach the configuration-space address; the two low address bits always equal the two low port bits.

Defaults: CFG_PREFIX = 0x10_0000_0000, IO_PREFIX = 0x20_0000_0000, physical address width 40. rdData is zero whenever neither R2's read nor R5's read applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accPort | input | 16 | I/O port number |
| accSize | input | 3 | Access size in bytes (1, 2 or 4) |
| accWrite | input | 1 | 1 = write, 0 = read |
| accWdata | input | 32 | Write data |
| tgtClass | output | 2 | 0 none, 1 address register, 2 configuration space, 3 I/O space |
| physAddr | output | 40 | Routed physical address |
| rdData | output | 32 | Register value, all-ones for a disabled window read, else zero |

## Verification
Two functions can meet at a single clock edge: the register load started by a write to 0xCF8, and the window decode of the access that follows it. The bench provokes this by writing the register and presenting a data-window access in the very next cycle, with no idle gap. It then compares the class and address against values computed from the just-written data. The same back-to-back pattern is repeated with the enable bit cleared, so that a window that closes at that edge is seen immediately as target none with an all-ones read.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef enum logic [1:0] {
    TGT_NONE      = 2'd0,
    TGT_CFG_REG   = 2'd1,
    TGT_CFG_SPACE = 2'd2,
    TGT_IO_SPACE  = 2'd3
  } tgt_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic hitReg;   // full-width access to the address port
    logic hitWin;   // access inside the data window
    logic hitIo;    // everything else
    logic isRead;
    logic loadReg;  // register load at the next edge
  } strobe_t;

  localparam logic [15:0] ADDR_PORT_DEF = 16'h0CF8;
  localparam logic [15:0] DATA_PORT_DEF = 16'h0CFC;

endpackage

// File: rtl/cfgr_ctrl.sv
module cfgr_ctrl
  import cfgr_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int SIZE_W = 3,
  parameter logic [PORT_W-1:0] ADDR_PORT = PORT_W'(ADDR_PORT_DEF),
  parameter logic [PORT_W-1:0] DATA_PORT = PORT_W'(DATA_PORT_DEF),
  parameter int REG_BYTES = 4
) (
  input  logic              accValid,
  input  logic [PORT_W-1:0] accPort,
  input  logic [SIZE_W-1:0] accSize,
  input  logic              accWrite,
  output strobe_t           strb
);

  localparam logic [PORT_W-1:0] WIN_MASK = ~PORT_W'(REG_BYTES - 1);
  localparam logic [SIZE_W-1:0] FULL_SIZE = SIZE_W'(REG_BYTES);

  logic isAddrPort;
  logic isFull;
  logic inWin;

  always_comb begin
    isAddrPort = (accPort == ADDR_PORT);
    isFull     = (accSize == FULL_SIZE);
    inWin      = ((accPort & WIN_MASK) == DATA_PORT);

    strb.hitReg  = accValid && isAddrPort && isFull;
    strb.hitWin  = accValid && inWin;
    strb.hitIo   = accValid && !(isAddrPort && isFull) && !inWin;
    strb.isRead  = accValid && !accWrite;
    strb.loadReg = accValid && isAddrPort && isFull && accWrite;
  end

endmodule

// File: rtl/cfgr_datapath.sv
module cfgr_datapath
  import cfgr_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int DATA_W = 32,
  parameter int PA_W   = 40,
  parameter int EN_BIT = 31,
  parameter int LANE_W = 2,
  parameter logic [PA_W-1:0] CFG_PREFIX = 40'h10_0000_0000,
  parameter logic [PA_W-1:0] IO_PREFIX  = 40'h20_0000_0000,
  parameter logic [PA_W-1:0] REG_PA     = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [PORT_W-1:0] accPort,
  input  logic [DATA_W-1:0] accWdata,
  output tgt_e              tgtClass,
  output logic [PA_W-1:0]   physAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int OFS_W = EN_BIT - LANE_W;

  logic [DATA_W-1:0] cfgReg;
  logic              winEn;
  logic [PA_W-1:0]   cfgSpaceAddr;
  logic [PA_W-1:0]   ioAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (strb.loadReg) begin
      cfgReg <= accWdata;
    end
  end

  assign winEn = cfgReg[EN_BIT];

  always_comb begin
    cfgSpaceAddr = CFG_PREFIX |
                   PA_W'({cfgReg[EN_BIT-1:LANE_W], accPort[LANE_W-1:0]});
    ioAddr       = IO_PREFIX | PA_W'(accPort);
  end

  always_comb begin
    tgtClass = TGT_NONE;
    physAddr = '0;
    if (strb.hitReg) begin
      tgtClass = TGT_CFG_REG;
      physAddr = REG_PA;
    end else if (strb.hitWin) begin
      if (winEn) begin
        tgtClass = TGT_CFG_SPACE;
        physAddr = cfgSpaceAddr;
      end
    end else if (strb.hitIo) begin
      tgtClass = TGT_IO_SPACE;
      physAddr = ioAddr;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.isRead && strb.hitReg) begin
      rdData = cfgReg;
    end else if (strb.isRead && strb.hitWin && !winEn) begin
      rdData = '1;
    end
  end

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadReg |=> cfgReg == $past(accWdata)); // R2
  AST_REG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadReg |=> $stable(cfgReg)); // R3
  AST_WIN_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hitWin && !cfgReg[EN_BIT]) |-> (tgtClass == TGT_NONE && physAddr == '0)); // R5
  AST_OFS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (tgtClass == TGT_CFG_SPACE) |-> physAddr[OFS_W+LANE_W-1:LANE_W] == cfgReg[EN_BIT-1:LANE_W]); // R4

endmodule

// File: rtl/cfgr_top.sv
module cfgr_top
  import cfgr_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 32,
  parameter int PA_W   = 40,
  parameter logic [PA_W-1:0] CFG_PREFIX = 40'h10_0000_0000,
  parameter logic [PA_W-1:0] IO_PREFIX  = 40'h20_0000_0000,
  parameter logic [PA_W-1:0] REG_PA     = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [PORT_W-1:0] accPort,
  input  logic [SIZE_W-1:0] accSize,
  input  logic              accWrite,
  input  logic [DATA_W-1:0] accWdata,
  output logic [1:0]        tgtClass,
  output logic [PA_W-1:0]   physAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int EN_BIT = DATA_W - 1;
  localparam int LANE_W = $clog2(DATA_W / 8);

  strobe_t strb;
  tgt_e    tgtEnum;

  cfgr_ctrl #(
    .PORT_W    (PORT_W),
    .SIZE_W    (SIZE_W),
    .ADDR_PORT (PORT_W'(ADDR_PORT_DEF)),
    .DATA_PORT (PORT_W'(DATA_PORT_DEF)),
    .REG_BYTES (DATA_W / 8)
  ) ctrl_i (
    .accValid (accValid),
    .accPort  (accPort),
    .accSize  (accSize),
    .accWrite (accWrite),
    .strb     (strb)
  );

  cfgr_datapath #(
    .PORT_W     (PORT_W),
    .DATA_W     (DATA_W),
    .PA_W       (PA_W),
    .EN_BIT     (EN_BIT),
    .LANE_W     (LANE_W),
    .CFG_PREFIX (CFG_PREFIX),
    .IO_PREFIX  (IO_PREFIX),
    .REG_PA     (REG_PA)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .accPort  (accPort),
    .accWdata (accWdata),
    .tgtClass (tgtEnum),
    .physAddr (physAddr),
    .rdData   (rdData)
  );

  assign tgtClass = tgtEnum;

  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (tgtClass == 2'd0 && physAddr == '0)); // R8
  AST_LANE_FROM_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (tgtClass == 2'd2) |-> physAddr[LANE_W-1:0] == accPort[LANE_W-1:0]); // R9
  AST_IO_CARRIES_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (tgtClass == 2'd3) |-> physAddr[PORT_W-1:0] == accPort); // R6
  AST_NARROW_NOT_REG: assert property (@(posedge clk) disable iff (!rstN)
    (tgtClass == 2'd1) |-> accSize == SIZE_W'(DATA_W / 8)); // R3

endmodule

// File: tb/cfgr_top_tb_top.sv
module cfgr_top_tb_top;

  localparam logic [39:0] CFGP  = 40'h10_0000_0000;
  localparam logic [39:0] IOP   = 40'h20_0000_0000;
  localparam logic [39:0] REGPA = 40'h0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [15:0] accPort = '0;
  logic [2:0]  accSize = '0;
  logic        accWrite = 1'b0;
  logic [31:0] accWdata = '0;
  logic [1:0]  tgtClass;
  logic [39:0] physAddr;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  cfgr_top dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accPort(accPort),
    .accSize(accSize), .accWrite(accWrite), .accWdata(accWdata),
    .tgtClass(tgtClass), .physAddr(physAddr), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present an access at a falling edge; outputs are sampled 5 ns later.
  task automatic drive(input logic v, input logic [15:0] p, input logic [2:0] s,
                       input logic w, input logic [31:0] d);
    @(negedge clk);
    accValid = v; accPort = p; accSize = s; accWrite = w; accWdata = d;
    #5;
  endtask

  task automatic t_reset();
    drive(1, 16'h0CF8, 3'd4, 0, 32'h0);
    chk("R1 reg read class", 64'(tgtClass), 64'd1);
    chk("R1 reg read data", 64'(rdData), 64'h0);
    drive(1, 16'h0CFC, 3'd4, 0, 32'h0);
    chk("R1 window closed class", 64'(tgtClass), 64'd0);
  endtask

  task automatic t_reg_rw();
    drive(1, 16'h0CF8, 3'd4, 1, 32'h8000_1234);
    chk("R2 reg write class", 64'(tgtClass), 64'd1);
    chk("R2 reg write addr", 64'(physAddr), 64'(REGPA));
    drive(1, 16'h0CF8, 3'd4, 0, 32'h0);
    chk("R2 reg readback", 64'(rdData), 64'h8000_1234);
  endtask

  task automatic t_back_to_back();
    drive(1, 16'h0CF8, 3'd4, 1, 32'h8012_3457);
    drive(1, 16'h0CFE, 3'd1, 0, 32'h0);   // very next cycle
    chk("R7 new value class", 64'(tgtClass), 64'd2);
    chk("R4 R9 cfg addr lane 2", 64'(physAddr), 64'(CFGP | 40'h0012_3456));
    drive(1, 16'h0CFD, 3'd1, 1, 32'hAA);
    chk("R9 cfg addr lane 1", 64'(physAddr), 64'(CFGP | 40'h0012_3455));
    drive(1, 16'h0CFC, 3'd4, 0, 32'h0);
    chk("R4 cfg addr lane 0", 64'(physAddr), 64'(CFGP | 40'h0012_3454));
    chk("R4 rdData zero when open", 64'(rdData), 64'h0);
  endtask

  task automatic t_narrow();
    drive(1, 16'h0CF8, 3'd2, 1, 32'h0000_FFFF);
    chk("R3 narrow class", 64'(tgtClass), 64'd3);
    chk("R3 narrow addr", 64'(physAddr), 64'(IOP | 40'h0CF8));
    drive(1, 16'h0CF8, 3'd1, 1, 32'h0000_0000);
    chk("R3 byte class", 64'(tgtClass), 64'd3);
    drive(1, 16'h0CF8, 3'd4, 0, 32'h0);
    chk("R3 reg untouched", 64'(rdData), 64'h8012_3457);
  endtask

  task automatic t_other_ports();
    drive(1, 16'h0080, 3'd1, 1, 32'h5);
    chk("R6 port 0080 class", 64'(tgtClass), 64'd3);
    chk("R6 port 0080 addr", 64'(physAddr), 64'(IOP | 40'h0080));
    drive(1, 16'h0CFB, 3'd1, 0, 32'h0);
    chk("R6 port 0CFB addr", 64'(physAddr), 64'(IOP | 40'h0CFB));
    drive(1, 16'h0D00, 3'd4, 0, 32'h0);
    chk("R6 port 0D00 addr", 64'(physAddr), 64'(IOP | 40'h0D00));
    drive(1, 16'h0CF9, 3'd4, 0, 32'h0);
    chk("R6 port 0CF9 class", 64'(tgtClass), 64'd3);
  endtask

  task automatic t_idle();
    drive(0, 16'h0CF8, 3'd4, 1, 32'h0000_0001);
    chk("R8 idle class", 64'(tgtClass), 64'd0);
    chk("R8 idle addr", 64'(physAddr), 64'h0);
    drive(1, 16'h0CF8, 3'd4, 0, 32'h0);
    chk("R8 reg kept", 64'(rdData), 64'h8012_3457);
  endtask

  task automatic t_disabled();
    drive(1, 16'h0CF8, 3'd4, 1, 32'h0000_1234);
    drive(1, 16'h0CFF, 3'd1, 0, 32'h0);   // very next cycle
    chk("R5 closed class", 64'(tgtClass), 64'd0);
    chk("R5 closed addr", 64'(physAddr), 64'h0);
    chk("R5 closed read ones", 64'(rdData), 64'hFFFF_FFFF);
    drive(1, 16'h0CFC, 3'd4, 1, 32'h1);
    chk("R5 closed write class", 64'(tgtClass), 64'd0);
  endtask

  initial begin
    #200000000;
    nFails++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_reg_rw();
    t_back_to_back();
    t_narrow();
    t_other_ports();
    t_idle();
    t_disabled();
    drive(0, 16'h0, 3'd0, 0, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule